// File: doc/BRIEF.md
# Instruction Sequence Number Tagger

This block gives every instruction that enters an out-of-order instruction queue an age tag. The tag comes from a free-running counter that steps by the number of instructions accepted in each cycle, and up to two instructions can be accepted per cycle. The counter wraps silently. A separate combinational age comparator takes any two tags and reports which one is older. The comparator works on the sign of the wrapped difference of the two tags. Ordering therefore stays correct across a wrap, as long as fewer than half of all tag values are in flight at the same time.

Software can restart the tag space by flipping a control bit. The block compares that bit with the value it sampled one clock earlier. Any change clears the counter to zero and raises a one-cycle flush request, so the queue can drop the instructions that still hold tags from before the restart. The tag width is a parameter. The default is 32 bits, and a much narrower width makes wraparound easy to reach.

Top module: `seqtag_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tag_lo` is zero and `flush_req` is low.
- R2: When no clear event occurs, each rising clock edge adds `alloc_count` to `tag_lo`, modulo 2^TAG_W. The encoding of `alloc_count` is 0 for none, 1 for one instruction and 2 for two instructions. The value 3 is not used.
- R3: `tag_hi` always equals `tag_lo + 1` modulo 2^TAG_W, and is the tag given to the second instruction in a two-wide allocation.
- R4: The counter passes from all-ones to zero and onward with no other effect: `flush_req` stays low and counting continues.
- R5: `a_older` is 1 exactly when bit TAG_W-1 of `(cmp_a - cmp_b)` mod 2^TAG_W is 1. Equal tags give 0.
- R6: For two tags whose forward distance is below 2^(TAG_W-1), the comparator orders them correctly even when the newer tag has wrapped to a smaller unsigned value.
- R7: On a rising edge where `clr_bit` differs from its value sampled at the previous edge, `tag_lo` becomes zero. Changes in either direction count, and any allocation presented in that cycle is discarded. The sampled value is 0 after reset.
- R8: `flush_req` is high for exactly the one cycle after a clear event, in which `tag_lo` reads zero. It is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_count | input | 2 | Instructions entering the queue this cycle (0..2) |
| clr_bit | input | 1 | Control bit; any change restarts the tag space |
| cmp_a | input | TAG_W | First tag to compare |
| cmp_b | input | TAG_W | Second tag to compare |
| tag_lo | output | TAG_W | Tag for the first instruction this cycle |
| tag_hi | output | TAG_W | Tag for the second instruction this cycle |
| flush_req | output | 1 | One-cycle queue flush request after a restart |
| a_older | output | 1 | High when `cmp_a` is older than `cmp_b` |

## Verification
The assertions take for granted that `alloc_count` never carries 3 and that `clr_bit` is stable across each clock edge. The bench drives only the values 0, 1 and 2 and changes `clr_bit` on falling edges. The comparator's ordering guarantee holds only inside the half-space window. The bench therefore sweeps every pair of a 4-bit configuration and checks the sign rule itself, rather than checking an age relation that would break outside that window. Counter sequences are long enough to wrap several times, and clear events are placed both on idle cycles and on cycles with allocations.

// File: rtl/seqtag_pkg.sv
package seqtag_pkg;
  typedef enum logic [1:0] {
    ALLOC_NONE = 2'd0,
    ALLOC_ONE  = 2'd1,
    ALLOC_TWO  = 2'd2
  } alloc_amt_e;

  localparam int ALLOC_MAX = 2;
endpackage

// File: rtl/seqtag_clr_detect.sv
module seqtag_clr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_bit,
  output logic clr_evt,
  output logic flush_req
);
  logic clr_q;

  // a change of the control bit against its last sampled value is an event
  assign clr_evt = clr_bit ^ clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_q     <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      clr_q     <= clr_bit;
      flush_req <= clr_evt;
    end
  end
endmodule

// File: rtl/seqtag_counter.sv
module seqtag_counter #(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       alloc_count,
  output logic [TAG_W-1:0] tag_lo,
  output logic [TAG_W-1:0] tag_hi
);
  import seqtag_pkg::*;

  function automatic logic [TAG_W-1:0] tag_step(input logic [TAG_W-1:0] t,
                                                input logic [1:0] n);
    return t + TAG_W'(n);
  endfunction

  logic [TAG_W-1:0] cnt_q;
  logic [TAG_W-1:0] cnt_d;

  always_comb begin
    if (clear) cnt_d = '0;
    else       cnt_d = tag_step(cnt_q, alloc_count);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tag_lo = cnt_q;
  assign tag_hi = tag_step(cnt_q, 2'(ALLOC_ONE));

  // input assumption: encoding 3 never presented
  assert_alloc_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_count <= 2'(ALLOC_MAX));

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (tag_lo == $past(tag_lo) + TAG_W'($past(alloc_count))));
endmodule

// File: rtl/seqtag_age_cmp.sv
module seqtag_age_cmp #(
  parameter int TAG_W = 32
) (
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  output logic             a_older
);
  function automatic logic diff_negative(input logic [TAG_W-1:0] a,
                                         input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return d[TAG_W-1];
  endfunction

  assign a_older = diff_negative(tag_a, tag_b);

  always_comb begin
    if (tag_a == tag_b) begin
      assert_equal_not_older_R5: assert (!a_older);
    end
  end
endmodule

// File: rtl/seqtag_top.sv
module seqtag_top #(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       alloc_count,
  input  logic             clr_bit,
  input  logic [TAG_W-1:0] cmp_a,
  input  logic [TAG_W-1:0] cmp_b,
  output logic [TAG_W-1:0] tag_lo,
  output logic [TAG_W-1:0] tag_hi,
  output logic             flush_req,
  output logic             a_older
);
  logic clr_evt;

  seqtag_clr_detect u_clr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_bit   (clr_bit),
    .clr_evt   (clr_evt),
    .flush_req (flush_req)
  );

  seqtag_counter #(.TAG_W(TAG_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (clr_evt),
    .alloc_count (alloc_count),
    .tag_lo      (tag_lo),
    .tag_hi      (tag_hi)
  );

  seqtag_age_cmp #(.TAG_W(TAG_W)) u_cmp (
    .tag_a   (cmp_a),
    .tag_b   (cmp_b),
    .a_older (a_older)
  );

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (tag_lo == '0) && flush_req);

  assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (tag_lo == '0));
endmodule

// File: tb/seqtag_top_bench.sv
module seqtag_top_bench;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   alloc_count = 2'd0;
  logic         clr_bit = 1'b0;
  logic [W-1:0] cmp_a = '0;
  logic [W-1:0] cmp_b = '0;
  logic [W-1:0] tag_lo, tag_hi;
  logic         flush_req, a_older;

  int checks = 0;
  int fails = 0;
  int model = 0;
  bit exp_flush = 0;
  bit clr_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  seqtag_top #(.TAG_W(W)) u_seqtag_top (
    .clk(clk), .rst_n(rst_n), .alloc_count(alloc_count), .clr_bit(clr_bit),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .tag_lo(tag_lo), .tag_hi(tag_hi),
    .flush_req(flush_req), .a_older(a_older)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // one clock: drive at the falling edge, update the model at the rising edge, check at the next falling edge
  task automatic cyc(input int cnt, input bit clr, input string req);
    alloc_count = 2'(cnt);
    clr_bit = clr;
    @(posedge clk);
    if (clr != clr_prev) begin
      model = 0;
      exp_flush = 1;
    end else begin
      model = (model + cnt) % M;
      exp_flush = 0;
    end
    clr_prev = clr;
    @(negedge clk);
    chk(req, int'(tag_lo), model);
    chk("R3", int'(tag_hi), (model + 1) % M);
    chk("R8", int'(flush_req), int'(exp_flush));
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(tag_lo), 0);
    chk("R1", int'(flush_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(tag_lo), 0);
    chk("R1", int'(flush_req), 0);

    // R2 / R4: mixed allocation patterns, several wraps
    for (int i = 0; i < 60; i++) cyc(i % 3, 1'b0, "R2");
    for (int i = 0; i < 40; i++) cyc((i * 7 + 1) % 3, 1'b0, "R4");
    // force a pass through all-ones
    while (model != M - 1) cyc(1, 1'b0, "R2");
    cyc(1, 1'b0, "R4");
    chk("R4", int'(tag_lo), 0);

    // R7: rising change with allocation presented, then falling change while idle
    cyc(2, 1'b0, "R2");
    cyc(2, 1'b1, "R7");
    cyc(1, 1'b1, "R2");
    cyc(2, 1'b1, "R2");
    cyc(0, 1'b0, "R7");
    cyc(2, 1'b0, "R2");
    // back-to-back changes
    cyc(1, 1'b1, "R7");
    cyc(1, 1'b0, "R7");
    for (int i = 0; i < 20; i++) cyc(2, 1'b0, "R2");

    // R5 / R6: exhaustive comparator sweep
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        int fwd;
        cmp_a = W'(a);
        cmp_b = W'(b);
        #1;
        fwd = (a - b + M) % M;
        if (fwd != 0 && fwd < M / 2 && a < b)
          chk("R6", int'(a_older), 0);          // a wrapped yet newer
        else if (fwd >= M / 2 && a > b)
          chk("R6", int'(a_older), 1);          // b wrapped, a older
        else
          chk("R5", int'(a_older), (fwd >= M / 2) ? 1 : 0);
      end
    end

    done = 1;
    finish_run();
  end
endmodule